// File: doc/BRIEF.md
# Phase-Selectable Multi-Ratio Clock Divider

This block divides a fast stepping source into three groups of clock outputs whose rates stand in a 4:2:1 ratio. The fast group toggles on every source step (divide by 2), the middle group runs at divide by 4 and the slow group at divide by 8. All three are decoded from one free-running 3-bit counter, so their edges stay coherent. The slow group can be moved against the other two by a whole number of source steps, chosen by a 2-bit shift code.

The source is an advance pulse sampled on the system clock. In normal operation the oscillator-path tick advances the counter. In test mode a mux replaces it with the reference-path tick. A feedback select picks which group is copied to a feedback output for the phase comparison. That choice fixes which group runs at the reference rate: ÷8 for the slow group, ÷4 for the middle group, ÷2 for the fast group.

The reset input is asynchronous and active low. Inside the block its release is synchronised to the clock.

Top module: `phase_clk_divider`

## Requirements
- R1: While reset is asserted, and after its release until the first source step, every group output and the feedback output are low. Assertion of reset clears them at once, without waiting for a clock edge.
- R2: A source step is `osc_tick` when `test_mode` is 0 and `ref_tick` when `test_mode` is 1. The other tick has no effect, and no output changes in a cycle without a step.
- R3: Let k be the number of steps since reset release, so that the counter value is c = (k-1) mod 8 after step k. Group C is high when c is even. It therefore rises on the first step and toggles on every step.
- R4: Group B is high when bit 1 of c is 0. This gives a period of 4 steps, high for 2 of them, with its first rise on the first step, together with group C.
- R5: Group A is high when (c + off) mod 8 < 4. This gives a period of 8 steps with a 50% duty cycle.
- R6: The shift code sets off as follows: 00 → 6 (shift -2, rise at c=2); 01 → 7 (shift -1, rise at c=1); 10 → 0 (shift 0, rise at c=0); 11 → 1 (shift +1, rise at c=7).
- R7: `phase_sel` is sampled only on the step that brings c to 0, including the first step after reset, and applies from that step on. Values at other times have no effect. After reset, shift code 10 is in force until the first step.
- R8: All outputs of a group carry the same value in every cycle: 5 for group A, 4 for group B, 2 for group C.
- R9: On each step, `fb_out` takes the new value of the group chosen by `fb_sel` as sampled on that step: 00 group A, 01 group B, 10 or 11 group C.
- R10: Groups B and C do not depend on `phase_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which the tick inputs are sampled |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| test_mode | input | 1 | 1 selects the reference tick as the source (bypass) |
| osc_tick | input | 1 | Oscillator-path advance pulse |
| ref_tick | input | 1 | Reference-path advance pulse |
| phase_sel | input | 2 | Shift code for group A |
| fb_sel | input | 2 | Feedback group select |
| grp_a | output | 5 | Group A outputs, divide by 8, shiftable |
| grp_b | output | 4 | Group B outputs, divide by 4 |
| grp_c | output | 2 | Group C outputs, divide by 2 |
| fb_out | output | 1 | Copy of the selected feedback group |

## Verification
A continuous tick stream is run through every pairing of shift code and feedback select. This separates the four offsets by the step at which group A rises and shows which group reaches the feedback output. Test mode is exercised with only the foreign tick active and then with only the native tick active, which shows whether the bypass mux chooses the correct source. A long random stretch changes the shift code on nearly every cycle while ticks arrive sparsely. Any sampling of the code away from the wrap to zero shows up as a misplaced group A edge. Resets in mid-run confirm that the first edges of groups B and C fall on count zero again.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned CNT_W = 3;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    PH_LAG2  = 2'b00,
    PH_LAG1  = 2'b01,
    PH_ZERO  = 2'b10,
    PH_LEAD1 = 2'b11
  } phase_e;

  typedef enum logic [1:0] {
    FB_A     = 2'b00,
    FB_B     = 2'b01,
    FB_C     = 2'b10,
    FB_C_ALT = 2'b11
  } fb_e;

  // Offset added to the count before the slow group is decoded
  function automatic cnt_t phase_offset(phase_e p);
    cnt_t off;
    case (p)
      PH_LAG2:  off = cnt_t'(6);
      PH_LAG1:  off = cnt_t'(7);
      PH_ZERO:  off = cnt_t'(0);
      default:  off = cnt_t'(1);
    endcase
    return off;
  endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic osc_tick,
  input  logic ref_tick,
  output logic step,
  output logic wrap,
  output cnt_t cnt_nxt
);
  cnt_t cnt_q;

  // Bypass mux: the reference tick replaces the oscillator tick in test mode
  always_comb begin
    step    = test_mode ? ref_tick : osc_tick;
    cnt_nxt = step ? cnt_q + cnt_t'(1) : cnt_q;
    wrap    = step && (cnt_q == '1);
  end

  // Reset to the last count so that the first step lands on zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '1;
    else if (step) cnt_q <= cnt_nxt;
  end

  AST_BYPASS_IGNORES_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !ref_tick) |=> $stable(cnt_q)); // R2
  AST_NORMAL_IGNORES_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !osc_tick) |=> $stable(cnt_q)); // R2
  AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((test_mode ? ref_tick : osc_tick)) |=> (cnt_q == cnt_t'($past(cnt_q) + cnt_t'(1)))); // R3
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap,
  input  logic [1:0] phase_sel,
  output phase_e     phase_nxt
);
  phase_e phase_q;

  always_comb begin
    phase_nxt = wrap ? phase_e'(phase_sel) : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= PH_ZERO;
    else if (wrap) phase_q <= phase_nxt;
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(phase_q)); // R7
  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (phase_q == phase_e'($past(phase_sel)))); // R7
endmodule

// File: rtl/clkdiv_outputs.sv
module clkdiv_outputs
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_A = 5,
  parameter int unsigned NUM_B = 4,
  parameter int unsigned NUM_C = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  cnt_t             cnt_nxt,
  input  phase_e           phase_nxt,
  input  logic [1:0]       fb_sel,
  output logic [NUM_A-1:0] grp_a,
  output logic [NUM_B-1:0] grp_b,
  output logic [NUM_C-1:0] grp_c,
  output logic             fb_out
);
  localparam int unsigned MSB = CNT_W - 1;

  cnt_t a_idx;
  logic a_nxt;
  logic b_nxt;
  logic c_nxt;
  logic fb_nxt;

  always_comb begin
    a_idx = cnt_nxt + phase_offset(phase_nxt);
    a_nxt = ~a_idx[MSB];
    b_nxt = ~cnt_nxt[MSB-1];
    c_nxt = ~cnt_nxt[0];
    case (fb_e'(fb_sel))
      FB_A:    fb_nxt = a_nxt;
      FB_B:    fb_nxt = b_nxt;
      default: fb_nxt = c_nxt;
    endcase
  end

  // One flop per output pin, all enabled by the same step
  for (genvar g = 0; g < NUM_A; g++) begin : g_a
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    grp_a[g] <= 1'b0;
      else if (step) grp_a[g] <= a_nxt;
    end
  end

  for (genvar g = 0; g < NUM_B; g++) begin : g_b
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    grp_b[g] <= 1'b0;
      else if (step) grp_b[g] <= b_nxt;
    end
  end

  for (genvar g = 0; g < NUM_C; g++) begin : g_c
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    grp_c[g] <= 1'b0;
      else if (step) grp_c[g] <= c_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fb_out <= 1'b0;
    else if (step) fb_out <= fb_nxt;
  end

  AST_C_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (grp_c[0] != $past(grp_c[0]))); // R3
  AST_B_ON_C_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grp_b[0]) |-> $rose(grp_c[0])); // R4
  AST_A_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grp_a[0]) |-> $past(step)); // R5
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable({grp_a, grp_b, grp_c, fb_out})); // R2
endmodule

// File: rtl/phase_clk_divider.sv
module phase_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_A = 5,
  parameter int unsigned NUM_B = 4,
  parameter int unsigned NUM_C = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             osc_tick,
  input  logic             ref_tick,
  input  logic [1:0]       phase_sel,
  input  logic [1:0]       fb_sel,
  output logic [NUM_A-1:0] grp_a,
  output logic [NUM_B-1:0] grp_b,
  output logic [NUM_C-1:0] grp_c,
  output logic             fb_out
);
  logic   rst_sync_n;
  logic   step;
  logic   wrap;
  cnt_t   cnt_nxt;
  phase_e phase_nxt;

  clkdiv_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  clkdiv_counter i_counter (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .test_mode (test_mode),
    .osc_tick  (osc_tick),
    .ref_tick  (ref_tick),
    .step      (step),
    .wrap      (wrap),
    .cnt_nxt   (cnt_nxt)
  );

  clkdiv_phase i_phase (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wrap      (wrap),
    .phase_sel (phase_sel),
    .phase_nxt (phase_nxt)
  );

  clkdiv_outputs #(.NUM_A(NUM_A), .NUM_B(NUM_B), .NUM_C(NUM_C)) i_outputs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (step),
    .cnt_nxt   (cnt_nxt),
    .phase_nxt (phase_nxt),
    .fb_sel    (fb_sel),
    .grp_a     (grp_a),
    .grp_b     (grp_b),
    .grp_c     (grp_c),
    .fb_out    (fb_out)
  );

  AST_RESET_OUTPUTS_LOW: assert property (@(posedge clk)
    !rst_sync_n |-> ({grp_a, grp_b, grp_c, fb_out} == '0)); // R1
endmodule

// File: tb/test_phase_clk_divider.sv
module test_phase_clk_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_mode = 1'b0;
  logic       osc_tick = 1'b0;
  logic       ref_tick = 1'b0;
  logic [1:0] phase_sel = 2'b10;
  logic [1:0] fb_sel = 2'b00;
  logic [4:0] grp_a;
  logic [3:0] grp_b;
  logic [1:0] grp_c;
  logic       fb_out;

  int total = 0;
  int fails = 0;
  bit done = 0;

  int cnt_m = 7;
  int ph_m = 2;
  int fb_m = 0;
  bit started = 0;
  bit last_ign = 0;

  phase_clk_divider i_phase_clk_divider (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .osc_tick(osc_tick),
    .ref_tick(ref_tick), .phase_sel(phase_sel), .fb_sel(fb_sel),
    .grp_a(grp_a), .grp_b(grp_b), .grp_c(grp_c), .fb_out(fb_out)
  );

  always #10 clk = ~clk;

  function automatic bit model_a(int c, int ph);
    int off;
    off = (ph == 0) ? 6 : (ph == 1) ? 7 : (ph == 2) ? 0 : 1;
    return ((c + off) % 8) < 4;
  endfunction

  function automatic bit model_b(int c);
    return ((c >> 1) & 1) == 0;
  endfunction

  function automatic bit model_c(int c);
    return (c & 1) == 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit ea, eb, ec, ef;
    ea = started ? model_a(cnt_m, ph_m) : 1'b0;
    eb = started ? model_b(cnt_m) : 1'b0;
    ec = started ? model_c(cnt_m) : 1'b0;
    ef = (fb_m == 0) ? ea : (fb_m == 1) ? eb : ec;
    if (!started) begin
      chk("R1", int'({grp_a, grp_b, grp_c, fb_out}), 0);
    end else begin
      chk("R5,R6,R7,R8", int'(grp_a), int'({5{ea}}));
      chk("R4,R8,R10", int'(grp_b), int'({4{eb}}));
      chk(last_ign ? "R2" : "R3,R8,R10", int'(grp_c), int'({2{ec}}));
      chk("R9", int'(fb_out), int'(ef));
    end
  endtask

  // Check the state left by the previous cycle, then apply new inputs
  task automatic cycle(bit t, bit o, bit r, int ps, int fs);
    bit st;
    @(negedge clk);
    check_all();
    test_mode = t; osc_tick = o; ref_tick = r;
    phase_sel = 2'(ps); fb_sel = 2'(fs);
    st = t ? r : o;
    last_ign = !st && (o || r);
    if (st) begin
      cnt_m = (cnt_m + 1) % 8;
      started = 1;
      if (cnt_m == 0) ph_m = ps;
      fb_m = (fs == 3) ? 2 : fs;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    osc_tick = 0; ref_tick = 0;
    rst_n = 0;
    #1;
    chk("R1", int'({grp_a, grp_b, grp_c, fb_out}), 0);
    cnt_m = 7; ph_m = 2; started = 0; last_ign = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 2, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", int'({grp_a, grp_b, grp_c, fb_out}), 0);
    do_reset();
    // Directed sweep of every shift code and feedback select (R6, R9)
    for (int ps = 0; ps < 4; ps++)
      for (int fs = 0; fs < 4; fs++)
        for (int i = 0; i < 24; i++) cycle(0, 1, 0, ps, fs);
    // Test mode: only the foreign tick, then only the native tick (R2)
    for (int i = 0; i < 20; i++) cycle(1, 1, 0, 3, 1);
    for (int i = 0; i < 20; i++) cycle(1, 0, 1, 0, 2);
    for (int i = 0; i < 20; i++) cycle(0, 0, 1, 1, 0);
    // Mid-run reset, first edges again at count zero (R1, R4)
    for (int i = 0; i < 5; i++) cycle(0, 1, 0, 0, 1);
    do_reset();
    for (int i = 0; i < 16; i++) cycle(0, 1, 0, 3, 0);
    // Random stretch with a changing shift code (R7)
    for (int i = 0; i < 4000; i++) begin
      bit t, o, r;
      t = ($urandom % 4) == 0;
      o = ($urandom % 3) != 0;
      r = ($urandom % 2) == 0;
      cycle(t, o, r, int'($urandom % 4), int'($urandom % 4));
    end
    do_reset();
    for (int i = 0; i < 10; i++) cycle(0, 1, 0, 0, 2);
    @(negedge clk);
    check_all();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule